// File: doc/BRIEF.md
# Three-Wire Phase-Order Sender

This block sends a 3-bit symbol over three wires, named a, b and c. The value is carried only by the order in which the wires make their transitions. Each valid symbol maps to one of the six possible orderings of the three wires. Every wire is driven through its own request/acknowledge handshake toward the channel.

The block handles the three wire events as one shared set. It does not hold six separate sequences. Between every ordered pair of wires there is a precedence arc, and that arc is enabled by a Boolean function of the symbol bits. A wire's request rises only after its enabled predecessor has acknowledged. When all three acknowledges are high, a completion flag rises. Dropping the start input returns every output to zero. The symbol bits must stay constant from before start rises until the completion flag has fallen.

The two unused codes raise an error flag, and no wire is driven for them. A receiver recovers the symbol by watching which wire fires first, second and third.

Top module: `phase_order_sender`

## Requirements
- R1: While reset is high, and on the clock edge that follows it, `req`, `done` and `err` are all zero.
- R2: The order of request rises follows `code` = {r,s,t}. Here `req[0]` is wire a, `req[1]` is wire b and `req[2]` is wire c. The orders are: 000 gives a,b,c; 001 gives a,c,b; 010 gives b,a,c; 011 gives b,c,a; 100 gives c,a,b; 101 gives c,b,a.
- R3: Wire a fires immediately before wire b exactly when `code[1:0]` is 00. The value of `code[2]` does not change this.
- R4: A request rises only while `start` is high. It rises only once the acknowledge of the wire directly before it in the order is high. The first wire rises on the clock edge after `start` is seen high.
- R5: No two requests rise on the same clock edge.
- R6: `done` rises on the edge after all three acknowledges are high while `start` is high. It then stays high until `start` falls.
- R7: For codes 110 and 111, `err` rises on the edge after `start` is seen high, and no request is ever raised.
- R8: On the first edge at which `start` is sampled low, `req`, `done` and `err` all become zero on the following cycle.
- R9: Once a request is high, it stays high for as long as `start` stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins sending the symbol and holds the transaction open |
| code | input | 3 | Symbol {r,s,t}; must be held while the transaction is open |
| ack | input | 3 | Channel acknowledges for wires a, b and c |
| req | output | 3 | Wire requests for a, b and c (registered) |
| done | output | 1 | All three wires have completed their handshakes |
| err | output | 1 | The symbol code is one of the two invalid values |

## Verification
All six valid codes are sent, and each recorded firing order is compared with the expected permutation. Codes 000 and 100 share their low bits, so they show whether the a-before-b arc really ignores the top bit. Each code is tried with acknowledge delays of zero and of several cycles. A delay of zero tests that one-cycle spacing is kept even against an immediate acknowledge, and the longer delays test that a request waits for its predecessor. Both invalid codes are sent between valid ones to test that the error flag fires and that no wire moves. After every symbol, dropping start tests the return to zero.

// File: rtl/phs_pkg.sv
package phs_pkg;
  localparam int NW      = 3;
  localparam int CODE_W  = 3;
  localparam int SLOT_W  = $clog2(NW);

  typedef logic [SLOT_W-1:0] slot_t;
  typedef logic [NW*SLOT_W-1:0] slot_vec_t;

  // Firing slot of each wire, packed {c,b,a}; returns validity through the top bit.
  function automatic logic [NW*SLOT_W:0] slots_for(input logic [CODE_W-1:0] code);
    logic [NW*SLOT_W:0] v;
    case (code)
      3'b000:  v = {1'b1, 2'd2, 2'd1, 2'd0};
      3'b001:  v = {1'b1, 2'd1, 2'd2, 2'd0};
      3'b010:  v = {1'b1, 2'd2, 2'd0, 2'd1};
      3'b011:  v = {1'b1, 2'd1, 2'd0, 2'd2};
      3'b100:  v = {1'b1, 2'd0, 2'd2, 2'd1};
      3'b101:  v = {1'b1, 2'd0, 2'd1, 2'd2};
      default: v = '0;
    endcase
    return v;
  endfunction
endpackage

// File: rtl/phs_arc_decode.sv
module phs_arc_decode
  import phs_pkg::*;
#(
  parameter int N_WIRES = NW,
  parameter int CW      = CODE_W,
  localparam int SW     = SLOT_W
) (
  input  logic [CW-1:0]              code,
  output logic                       valid,
  output logic [N_WIRES*N_WIRES-1:0] arc
);
  logic [N_WIRES*SW:0] slots;
  assign slots = slots_for(code);
  assign valid = slots[N_WIRES*SW];

  // arc[i*N+j]: wire i is the immediate predecessor of wire j
  for (genvar i = 0; i < N_WIRES; i++) begin : g_from
    for (genvar j = 0; j < N_WIRES; j++) begin : g_to
      if (i == j) begin : g_self
        assign arc[i*N_WIRES+j] = 1'b0;
      end else begin : g_pair
        assign arc[i*N_WIRES+j] = valid &&
          (slots[j*SW +: SW] == slots[i*SW +: SW] + SW'(1));
      end
    end
  end
endmodule

// File: rtl/phs_wire_ctrl.sv
module phs_wire_ctrl #(
  parameter int N_WIRES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               valid,
  input  logic [N_WIRES-1:0] pred_en,
  input  logic [N_WIRES-1:0] ack,
  output logic               req
);
  logic ready;
  logic req_q;
  assign ready = &(~pred_en | ack);

  always_ff @(posedge clk) begin
    if (rst) req_q <= 1'b0;
    else     req_q <= start & valid & (req_q | ready);
  end
  assign req = req_q;

  AST_REQ_NEEDS_START: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(start)); // R4
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (start && req_q) |=> req_q); // R9
endmodule

// File: rtl/phs_status.sv
module phs_status #(
  parameter int N_WIRES = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               valid,
  input  logic [N_WIRES-1:0] ack,
  output logic               done,
  output logic               err
);
  logic done_q, err_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= start & valid & (&ack);
      err_q  <= start & ~valid;
    end
  end
  assign done = done_q;
  assign err  = err_q;

  AST_DONE_AFTER_ACKS: assert property (@(posedge clk) disable iff (rst)
    done_q |-> ($past(&ack) && $past(start))); // R6
endmodule

// File: rtl/phase_order_sender.sv
module phase_order_sender
  import phs_pkg::*;
#(
  parameter int N_WIRES = NW,
  parameter int CW      = CODE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CW-1:0]    code,
  input  logic [N_WIRES-1:0] ack,
  output logic [N_WIRES-1:0] req,
  output logic             done,
  output logic             err
);
  logic                       valid;
  logic [N_WIRES*N_WIRES-1:0] arc;

  phs_arc_decode #(.N_WIRES(N_WIRES), .CW(CW)) u_dec (
    .code (code),
    .valid(valid),
    .arc  (arc)
  );

  for (genvar k = 0; k < N_WIRES; k++) begin : g_wire
    logic [N_WIRES-1:0] col;
    for (genvar i = 0; i < N_WIRES; i++) begin : g_col
      assign col[i] = arc[i*N_WIRES+k];
    end
    phs_wire_ctrl #(.N_WIRES(N_WIRES)) u_wire (
      .clk    (clk),
      .rst    (rst),
      .start  (start),
      .valid  (valid),
      .pred_en(col),
      .ack    (ack),
      .req    (req[k])
    );
  end

  phs_status #(.N_WIRES(N_WIRES)) u_stat (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .valid(valid),
    .ack  (ack),
    .done (done),
    .err  (err)
  );

  AST_AB_ARC: assert property (@(posedge clk) disable iff (rst)
    ($rose(req[1]) && code[1:0] == 2'b00) |-> ack[0]); // R3
  AST_ONE_EDGE: assert property (@(posedge clk) disable iff (rst)
    $countones(req & ~$past(req)) <= 1); // R5
  AST_RTZ: assert property (@(posedge clk) disable iff (rst)
    !start |=> (req == '0 && !done && !err)); // R8
  AST_BAD_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    (start && $past(start) && code[2:1] == 2'b11) |-> req == '0); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err |-> $past(code[2:1] == 2'b11)); // R7
endmodule

// File: tb/phase_order_sender_tb.sv
module phase_order_sender_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [2:0] code = 3'b000;
  logic [2:0] ack = 3'b000;
  logic [2:0] req;
  logic       done, err;

  int n_chk = 0, n_bad = 0;
  int ack_dly = 0;
  int cyc = 0;
  int exp_q[$];
  int rec[$];
  logic [2:0] prev_req = 3'b000;
  logic       prev_done = 1'b0;
  int cnt [3];

  always #2.5 clk = ~clk;

  phase_order_sender dut_i (
    .clk(clk), .rst(rst), .start(start), .code(code),
    .ack(ack), .req(req), .done(done), .err(err));

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Expected order packed as first*100+second*10+third (wire a=0,b=1,c=2)
  function automatic int exp_order(input logic [2:0] c);
    case (c)
      3'b000: return 012;
      3'b001: return 021;
      3'b010: return 102;
      3'b011: return 120;
      3'b100: return 201;
      3'b101: return 210;
      default: return -1;
    endcase
  endfunction

  // Channel responder: acknowledge after ack_dly cycles, release when request drops
  always @(negedge clk) begin
    cyc++;
    for (int k = 0; k < 3; k++) begin
      if (!req[k]) begin
        ack[k] <= 1'b0;
        cnt[k] = 0;
      end else if (!ack[k]) begin
        if (cnt[k] >= ack_dly) ack[k] <= 1'b1;
        else cnt[k]++;
      end
    end
  end

  // Monitor: record firing order and compare on completion
  always @(negedge clk) begin
    int rises;
    rises = 0;
    for (int k = 0; k < 3; k++) begin
      if (req[k] && !prev_req[k]) begin
        rec.push_back(k);
        rises++;
      end
      if (!req[k] && prev_req[k] && start)
        check(1'b0, "R9 request dropped while start high", 0, 1);
    end
    if (rises > 1) check(1'b0, "R5 simultaneous rises", rises, 1);
    if (done && !prev_done) begin
      int got, want;
      got = (rec.size() == 3) ? rec[0]*100 + rec[1]*10 + rec[2] : -rec.size();
      want = (exp_q.size() > 0) ? exp_q.pop_front() : -99;
      check(got == want, "R2/R3 firing order", got, want);
      check(ack == 3'b111, "R6 done with all acks", int'(ack), 7);
      rec.delete();
    end
    prev_req = req;
    prev_done = done;
  end

  task automatic send(input logic [2:0] c, input int dly);
    int t;
    bit bad;
    @(negedge clk);
    ack_dly = dly;
    code = c;
    start = 1'b1;
    bad = (c[2:1] == 2'b11);
    if (!bad) begin
      exp_q.push_back(exp_order(c));
      @(negedge clk);
      // R4: first wire up one edge after start, exactly one wire
      check($countones(req) == 1, "R4 first wire after start", $countones(req), 1);
      t = 0;
      while (!done && t < 60) begin @(negedge clk); t++; end
      check(done == 1'b1, "R6 done rises", done, 1);
      @(negedge clk);
      check(done == 1'b1 && req == 3'b111, "R6 done stays", done, 1);
    end else begin
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        check(req == 3'b000, "R7 no request on bad code", req, 0);
      end
      check(err == 1'b1, "R7 error flag", err, 1);
      check(done == 1'b0, "R7 no done", done, 0);
    end
    start = 1'b0;
    @(negedge clk);
    check(req == 3'b000 && !done && !err, "R8 return to zero",
          {req, done, err}, 0);
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(req == 3'b000 && !done && !err, "R1 reset state", {req, done, err}, 0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(req == 3'b000 && !done && !err, "R1 after reset", {req, done, err}, 0);
    for (int d = 0; d < 3; d++) begin
      for (int c = 0; c < 8; c++) send(3'(c), d * 2);
    end
    // R3: same low bits, different top bit
    send(3'b100, 1);
    send(3'b000, 4);
    check(exp_q.size() == 0, "R2 all symbols completed", exp_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule